// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

A bank of 32-bit control words for chip-level housekeeping. It sits behind a zero-wait APB slave port and decodes a 4 KiB window. The word index is the byte address shifted right by two. Only aligned accesses take effect.

All writes except those to the key word are discarded until a magic value has been written to word 0. Once unlocked, the bank offers:

- Reset-control and clock-stop words that can only be set, each with a neighbouring word that clears bits.
- Two strap words that a companion protect word can freeze against setting.
- Identity words that cannot be written.
- PLL extension words that always read back as locked.
- A random-data word that returns a new pseudo-random value on every read.

Everything else in range is plain storage.

At reset every word loads its default value. The strap words load the strap input ports. The key word comes up set or clear according to an input pin.

Top module: `sysctl_keyed_regs`

## Requirements
- R1: Word index = paddr[11:2]. An access with paddr[1:0] != 0 has no effect on any word and reads 0.
- R2: A write to word 0 (offset 0x000) stores 1 if pwdata equals parameter UNLOCK_KEY and 0 otherwise. Reading word 0 returns that stored value.
- R3: While word 0 holds 0, writes to every other word are discarded. Writes to word 0 are always accepted.
- R4: Offsets 0x040, 0x050, 0x080 and 0x090 are set-only: a write ORs pwdata into the stored value.
- R5: The word 4 bytes above each set-only word (0x044, 0x054, 0x084, 0x094) is its clear alias. Writing it clears every bit of the set-only word where pwdata is 1. The alias itself reads 0.
- R6: Strap words at 0x500 and 0x510 are set-only, with clear aliases at 0x504 and 0x514. A set write is dropped while the protect word 8 bytes above (0x508 or 0x518) is nonzero. Clears are never blocked by the protect word.
- R7: Reads of 0x204, 0x224 and 0x244 return the stored value with bit 31 forced to 1.
- R8: A read of 0x540 returns the state of a 32-bit Galois LFSR with polynomial x^32+x^22+x^2+x+1. The LFSR shifts right and XORs in mask 0x80200003 when the outgoing bit is 1. It advances once after each such read, and is loaded with LFSR_SEED at reset. Writes to 0x540 are ignored.
- R9: The revision words (0x004, 0x014) and chip-ID words (0x5B0, 0x5B4) hold their parameter values and ignore writes.
- R10: Reset behaviour:
  - Every word takes its default value; plain words default to 0.
  - Words 0x500 and 0x510 load strap1_in and strap2_in.
  - Word 0 loads boot_unlocked.
- R11: Word indices at or above NUM_REGS read 0, and writes to them change nothing.
- R12: Any other in-range word is plain read/write storage, up to and including the last implemented word.
- R13: pready is always 1 and pslverr always 0. A write lands at the clock edge of the access phase, and read data is valid during the access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address in the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always 0 |
| strap1_in | input | 32 | Reset value of strap word 1 |
| strap2_in | input | 32 | Reset value of strap word 2 |
| boot_unlocked | input | 1 | Key word reset value |

## Verification
The bench overrides the parameters below so that a wrong value in the RTL cannot pass unnoticed:

- UNLOCK_KEY and LFSR_SEED take non-default values, so a hard-coded key or seed in the RTL shows up as a mismatch.
- Every default word, identity word and strap input gets a distinct pattern, so each set, clear and ignored write has a unique expected result.

NUM_REGS stays at 368. With that size, offset 0x5BC is the last word of plain storage and 0x5C0 through 0xFFC are out of range, so the bench can hit both sides of the range boundary. A second reset with boot_unlocked high checks the unlocked power-up path and the reloaded seed.

// File: rtl/sysctl_keyed_regs.sv
module sysctl_keyed_regs #(
  parameter int          ADDR_W       = 12,
  parameter int          NUM_REGS     = 368,
  parameter logic [31:0] UNLOCK_KEY   = 32'hC0DE_5EED,
  parameter logic [31:0] LFSR_SEED    = 32'h0000_0001,
  parameter logic [31:0] RST_CTRL_DEF  = 32'hF7C3_FED8,
  parameter logic [31:0] RST_CTRL2_DEF = 32'h0DFF_FFFC,
  parameter logic [31:0] CLK_STOP_DEF  = 32'hFFFF_7F8A,
  parameter logic [31:0] CLK_STOP2_DEF = 32'hFFF0_FFF0,
  parameter logic [31:0] REV_ID       = 32'h0503_0303,
  parameter logic [31:0] REV2_ID      = 32'h0503_0303,
  parameter logic [31:0] CHIP_ID_LO   = 32'h1234_ABCD,
  parameter logic [31:0] CHIP_ID_HI   = 32'h8888_4444
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [31:0]       strap1_in,
  input  logic [31:0]       strap2_in,
  input  logic              boot_unlocked
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int RW    = $clog2(NUM_REGS);

  localparam logic [IDX_W-1:0] I_KEY    = IDX_W'(0);
  localparam logic [IDX_W-1:0] I_REV    = IDX_W'(1);
  localparam logic [IDX_W-1:0] I_REV2   = IDX_W'(5);
  localparam logic [IDX_W-1:0] I_RST    = IDX_W'(16);
  localparam logic [IDX_W-1:0] I_RST_C  = IDX_W'(17);
  localparam logic [IDX_W-1:0] I_RST2   = IDX_W'(20);
  localparam logic [IDX_W-1:0] I_RST2_C = IDX_W'(21);
  localparam logic [IDX_W-1:0] I_CLK    = IDX_W'(32);
  localparam logic [IDX_W-1:0] I_CLK_C  = IDX_W'(33);
  localparam logic [IDX_W-1:0] I_CLK2   = IDX_W'(36);
  localparam logic [IDX_W-1:0] I_CLK2_C = IDX_W'(37);
  localparam logic [IDX_W-1:0] I_PLLH   = IDX_W'(129);
  localparam logic [IDX_W-1:0] I_PLLM   = IDX_W'(137);
  localparam logic [IDX_W-1:0] I_PLLE   = IDX_W'(145);
  localparam logic [IDX_W-1:0] I_STR1   = IDX_W'(320);
  localparam logic [IDX_W-1:0] I_STR1_C = IDX_W'(321);
  localparam logic [IDX_W-1:0] I_STR2   = IDX_W'(324);
  localparam logic [IDX_W-1:0] I_STR2_C = IDX_W'(325);
  localparam logic [IDX_W-1:0] I_RNG    = IDX_W'(336);
  localparam logic [IDX_W-1:0] I_CHIP0  = IDX_W'(364);
  localparam logic [IDX_W-1:0] I_CHIP1  = IDX_W'(365);

  logic [31:0] regs [NUM_REGS];
  logic [31:0] lfsr;
  logic [31:0] rdata;

  wire [IDX_W-1:0] idx     = paddr[ADDR_W-1:2];
  wire [RW-1:0]    ri      = idx[RW-1:0];
  wire             in_rng  = (paddr[1:0] == 2'b00) && (idx < IDX_W'(NUM_REGS));
  wire             wr_acc  = psel & penable & pwrite & in_rng;
  wire             rd_acc  = psel & penable & ~pwrite & in_rng;
  wire             unlocked = regs[0][0];
  wire [31:0]      lfsr_nx = {1'b0, lfsr[31:1]} ^ (lfsr[0] ? 32'h8020_0003 : 32'h0);

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign prdata  = rdata;

  function automatic logic [31:0] init_word(input logic [IDX_W-1:0] i);
    case (i)
      I_KEY:   init_word = {31'b0, boot_unlocked};
      I_REV:   init_word = REV_ID;
      I_REV2:  init_word = REV2_ID;
      I_RST:   init_word = RST_CTRL_DEF;
      I_RST2:  init_word = RST_CTRL2_DEF;
      I_CLK:   init_word = CLK_STOP_DEF;
      I_CLK2:  init_word = CLK_STOP2_DEF;
      I_STR1:  init_word = strap1_in;
      I_STR2:  init_word = strap2_in;
      I_CHIP0: init_word = CHIP_ID_LO;
      I_CHIP1: init_word = CHIP_ID_HI;
      default: init_word = 32'h0;
    endcase
  endfunction

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      for (int i = 0; i < NUM_REGS; i++) regs[RW'(i)] <= init_word(IDX_W'(i));
      lfsr <= LFSR_SEED;
    end else begin
      if (rd_acc && idx == I_RNG) lfsr <= lfsr_nx;
      if (wr_acc) begin
        if (idx == I_KEY) begin
          regs[0] <= {31'b0, pwdata == UNLOCK_KEY};
        end else if (unlocked) begin
          case (idx)
            I_RST, I_RST2, I_CLK, I_CLK2:
              regs[ri] <= regs[ri] | pwdata;
            I_RST_C, I_RST2_C, I_CLK_C, I_CLK2_C, I_STR1_C, I_STR2_C:
              regs[ri - RW'(1)] <= regs[ri - RW'(1)] & ~pwdata;
            I_STR1, I_STR2:
              if (regs[ri + RW'(2)] == 32'h0) regs[ri] <= regs[ri] | pwdata;
            I_REV, I_REV2, I_RNG, I_CHIP0, I_CHIP1: ;
            default:
              regs[ri] <= pwdata;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata = 32'h0;
    if (in_rng) begin
      rdata = regs[ri];
      if (idx == I_PLLH || idx == I_PLLM || idx == I_PLLE) rdata[31] = 1'b1;
      if (idx == I_RNG) rdata = lfsr;
    end
  end
endmodule

// File: rtl/sysctl_keyed_regs_chk.sv
module sysctl_keyed_regs_chk #(
  parameter int          ADDR_W     = 12,
  parameter int          NUM_REGS   = 368,
  parameter logic [31:0] UNLOCK_KEY = 32'hC0DE_5EED
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic [31:0]       prdata,
  input logic [31:0]       regs [NUM_REGS],
  input logic [31:0]       lfsr
);
  wire acc = psel && penable;

  // R1
  misaligned_read_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
    acc && !pwrite && paddr[1:0] != 2'b00 |-> prdata == 32'h0);

  // R2
  key_update_chk: assert property (@(posedge pclk) disable iff (!presetn)
    acc && pwrite && paddr == ADDR_W'(0) |=> regs[0] == {31'b0, $past(pwdata) == UNLOCK_KEY});

  // R3
  locked_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
    acc && pwrite && regs[0] == 32'h0 && paddr == ADDR_W'('h40) |=> $stable(regs[16]));

  // R6
  strap_protect_chk: assert property (@(posedge pclk) disable iff (!presetn)
    acc && pwrite && paddr == ADDR_W'('h500) && regs[322] != 32'h0 |=> $stable(regs[320]));

  // R7
  pll_lock_chk: assert property (@(posedge pclk) disable iff (!presetn)
    acc && !pwrite && paddr == ADDR_W'('h204) |-> prdata[31]);

  // R8
  rng_step_chk: assert property (@(posedge pclk) disable iff (!presetn)
    acc && !pwrite && paddr == ADDR_W'('h540) |=> lfsr != $past(lfsr));

  // R9
  chip_id_ro_chk: assert property (@(posedge pclk) disable iff (!presetn)
    acc && pwrite && paddr == ADDR_W'('h5B0) |=> $stable(regs[364]));

  // R11
  out_of_range_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
    acc && !pwrite && 32'(paddr) >= 32'(NUM_REGS * 4) |-> prdata == 32'h0);
endmodule

bind sysctl_keyed_regs sysctl_keyed_regs_chk #(
  .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .UNLOCK_KEY(UNLOCK_KEY)
) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .regs(regs), .lfsr(lfsr)
);

// File: tb/sysctl_keyed_regs_test.sv
module sysctl_keyed_regs_test;
  localparam int          CLK_P = 10;
  localparam logic [31:0] KEY   = 32'h5EC0_1A7E;
  localparam logic [31:0] SEED  = 32'hACE1_0001;
  localparam logic [31:0] RST_D = 32'h0F0F_00F0;
  localparam logic [31:0] RST2_D = 32'h0000_FFFC;
  localparam logic [31:0] CLK_D = 32'h8000_7F8A;
  localparam logic [31:0] CLK2_D = 32'hFFF0_0000;
  localparam logic [31:0] REV   = 32'h0500_0303;
  localparam logic [31:0] REV2  = 32'h0500_0103;
  localparam logic [31:0] CID_LO = 32'h1357_9BDF;
  localparam logic [31:0] CID_HI = 32'h2468_ACE0;
  localparam logic [31:0] STRAP1 = 32'h0000_C3A5;
  localparam logic [31:0] STRAP2 = 32'h0000_0011;

  logic pclk = 0, presetn = 0, psel = 0, penable = 0, pwrite = 0, boot_unlocked = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, pslverr;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic [31:0] rng_m;

  always #(CLK_P/2) pclk = ~pclk;

  sysctl_keyed_regs #(
    .UNLOCK_KEY(KEY), .LFSR_SEED(SEED), .RST_CTRL_DEF(RST_D), .RST_CTRL2_DEF(RST2_D),
    .CLK_STOP_DEF(CLK_D), .CLK_STOP2_DEF(CLK2_D), .REV_ID(REV), .REV2_ID(REV2),
    .CHIP_ID_LO(CID_LO), .CHIP_ID_HI(CID_HI)
  ) uut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .strap1_in(STRAP1), .strap2_in(STRAP2), .boot_unlocked(boot_unlocked)
  );

  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic rng_read(input logic [11:0] a, input string tag);
    apb_read(a, rng_m, tag);
    rng_m = lfsr_step(rng_m);
  endtask

  always @(negedge pclk) begin
    #1;
    if (psel && penable && !pwrite) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard unexpected read actual %h expected none", prdata);
      end else begin
        check(tag_q.pop_front(), prdata, exp_q.pop_front());
      end
    end
  end

  task automatic do_reset(input logic unl);
    @(negedge pclk); presetn = 0; boot_unlocked = unl;
    repeat (2) @(negedge pclk);
    presetn = 1;
    rng_m = SEED;
  endtask

  initial begin
    repeat (20000) @(posedge pclk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    #1;
    check("R13 pready", {31'b0, pready}, 32'h1);
    check("R13 pslverr", {31'b0, pslverr}, 32'h0);
    apb_read(12'h000, 32'h0, "R10 key locked at reset");
    apb_read(12'h500, STRAP1, "R10 strap1 from port");
    apb_read(12'h510, STRAP2, "R10 strap2 from port");
    apb_read(12'h040, RST_D, "R10 reset ctrl default");
    apb_read(12'h004, REV, "R9 revision");
    apb_read(12'h5B4, CID_HI, "R9 chip id hi");

    apb_write(12'h100, 32'hDEAD_BEEF);
    apb_read(12'h100, 32'h0, "R3 locked plain write");
    apb_write(12'h040, 32'hFFFF_FFFF);
    apb_read(12'h040, RST_D, "R3 locked set write");

    apb_write(12'h000, KEY ^ 32'h1);
    apb_read(12'h000, 32'h0, "R2 wrong key");
    apb_write(12'h000, KEY);
    apb_read(12'h000, 32'h1, "R2 right key");

    apb_write(12'h100, 32'hA5A5_5A5A);
    apb_read(12'h100, 32'hA5A5_5A5A, "R12 plain word");
    apb_write(12'h104, 32'h0000_1234);
    apb_read(12'h104, 32'h0000_1234, "R12 plain word 2");

    apb_write(12'h040, 32'hF000_0001);
    apb_read(12'h040, 32'hFF0F_00F1, "R4 set reset ctrl");
    apb_write(12'h044, 32'h0F00_00F0);
    apb_read(12'h040, 32'hF00F_0001, "R5 clear reset ctrl");
    apb_read(12'h044, 32'h0, "R5 alias reads zero");
    apb_write(12'h050, 32'h0000_0003);
    apb_read(12'h050, 32'h0000_FFFF, "R4 set reset ctrl2");
    apb_write(12'h054, 32'h0000_FF00);
    apb_read(12'h050, 32'h0000_00FF, "R5 clear reset ctrl2");
    apb_write(12'h084, 32'h8000_0000);
    apb_read(12'h080, 32'h0000_7F8A, "R5 clear clock stop");
    apb_write(12'h090, 32'h0000_000F);
    apb_read(12'h090, 32'hFFF0_000F, "R4 set clock stop2");
    apb_write(12'h094, 32'hFF00_0000);
    apb_read(12'h090, 32'h00F0_000F, "R5 clear clock stop2");

    apb_write(12'h500, 32'h0001_0000);
    apb_read(12'h500, 32'h0001_C3A5, "R6 strap set open");
    apb_write(12'h508, 32'h0000_0001);
    apb_write(12'h500, 32'h00F0_0000);
    apb_read(12'h500, 32'h0001_C3A5, "R6 strap set protected");
    apb_write(12'h504, 32'h0000_0005);
    apb_read(12'h500, 32'h0001_C3A0, "R6 strap clear under protect");
    apb_write(12'h510, 32'h0000_0100);
    apb_read(12'h510, 32'h0000_0111, "R6 strap2 set open");

    apb_write(12'h204, 32'h0000_0012);
    apb_read(12'h204, 32'h8000_0012, "R7 pll ext h");
    apb_read(12'h224, 32'h8000_0000, "R7 pll ext m");
    apb_write(12'h244, 32'h8000_0001);
    apb_read(12'h244, 32'h8000_0001, "R7 pll ext e");

    rng_read(12'h540, "R8 rng first");
    rng_read(12'h540, "R8 rng second");
    rng_read(12'h540, "R8 rng third");
    apb_write(12'h540, 32'h0);
    rng_read(12'h540, "R8 rng after write");

    apb_write(12'h004, 32'hFFFF_FFFF);
    apb_read(12'h004, REV, "R9 revision write ignored");
    apb_write(12'h014, 32'h0);
    apb_read(12'h014, REV2, "R9 revision2 write ignored");
    apb_write(12'h5B0, 32'h0);
    apb_read(12'h5B0, CID_LO, "R9 chip id lo write ignored");

    apb_read(12'hFFC, 32'h0, "R11 top of window");
    apb_write(12'h5C0, 32'h1);
    apb_read(12'h5C0, 32'h0, "R11 first unimplemented word");
    apb_write(12'h5BC, 32'h7777_0001);
    apb_read(12'h5BC, 32'h7777_0001, "R12 last implemented word");

    apb_write(12'h102, 32'h0000_FFFF);
    apb_read(12'h100, 32'hA5A5_5A5A, "R1 misaligned write ignored");
    apb_read(12'h102, 32'h0, "R1 misaligned read zero");
    apb_read(12'h542, 32'h0, "R1 misaligned rng read zero");
    rng_read(12'h540, "R8 rng not advanced by misaligned read");

    apb_write(12'h000, 32'h0000_1234);
    apb_read(12'h000, 32'h0, "R2 relock");
    apb_write(12'h100, 32'h0);
    apb_read(12'h100, 32'hA5A5_5A5A, "R3 write after relock");

    do_reset(1'b1);
    apb_read(12'h000, 32'h1, "R10 key unlocked at reset");
    apb_read(12'h100, 32'h0, "R10 plain word default");
    apb_read(12'h500, STRAP1, "R10 strap reloaded");
    rng_read(12'h540, "R8 seed reloaded");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule